// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This block is the system-control slice of a 32-bit scalar core that owns exception entry, interrupt detection and the return-from-exception step. It holds three architectural registers: a processor state register (Status), an exception cause register (Cause) and an exception return address register (EPC). The pipeline reads and writes them through a register-number port. When the pipeline signals a fault, the block records the fault code, the faulting address and the branch-delay condition. It pushes a three-deep stack of kernel/user and interrupt-enable bit pairs. It also presents the address of the handler the pipeline must fetch next.

Six hardware interrupt lines and two software interrupt bits are combined with a mask in Status. Together with the current interrupt-enable bit they produce one interrupt-pending signal. The pipeline turns that signal into an exception request with code 0. A return strobe pops the mode stack. The block handles one event per cycle and always accepts it, so none of its inputs has back-pressure. When an exception, a return and a register write arrive in the same cycle, a fixed priority decides which one takes effect.

Top module: `trap_ctrl`

## Requirements
- R1: After reset, Status (register number 12) reads 0x00400000 with only the bootstrap-vector bit 22 set. Cause (13) and EPC (14) read 0, and `user_mode` is 0.
- R2: A write to Status keeps only the bits set in 0xF27FFF3F; every other bit reads 0. Register numbers other than 12, 13 and 14 read 0, and writes to them change nothing.
- R3: A write to Cause changes only the software-interrupt bits 9..8. A write to EPC stores all 32 bits.
- R4: On an exception request, Cause bits 6..2 take the 5-bit code and bits 29..28 take the coprocessor number. EPC takes the faulting PC, and bit 31 (branch delay) is cleared.
- R5: On an exception request with the delay-slot flag set, EPC takes the faulting PC minus 4 and Cause bit 31 is set.
- R6: On an exception request, Status bits 5..0 shift left by two places and the current pair (bit 1 kernel/user, bit 0 interrupt enable) becomes 0. The rest of Status is unchanged.
- R7: On a return strobe, Status bits 3..0 take the old value of bits 5..2. Bits 5..4 keep their value.
- R8: Cause bits 15..10 show the six hardware interrupt lines (line 0 at bit 10), sampled one clock earlier.
- R9: `irq_pending` is 1 exactly when Status bit 0 is 1 and the AND of Cause bits 15..8 with Status bits 15..8 is nonzero.
- R10: `vector_addr` is 0xBFC00180 when Status bit 22 is 1 and 0x80000080 when it is 0. When `exc_user_refill` is 1 it is 0xBFC00100 or 0x80000000 instead.
- R11: The priority is exception first, then return, then register write. A lower-priority event in the same cycle is dropped entirely.
- R12: `user_mode` equals Status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception entry strobe, one cycle per fault |
| exc_code | input | 5 | Fault code for Cause bits 6..2 |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_in_delay | input | 1 | Fault was taken in a branch delay slot |
| exc_cop | input | 2 | Coprocessor number for Cause bits 29..28 |
| exc_user_refill | input | 1 | Selects the refill handler offset (0x000 rather than 0x080) |
| hw_irq | input | 6 | Hardware interrupt lines |
| ret_req | input | 1 | Return-from-exception strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 5 | Register number for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_sel`, combinational |
| vector_addr | output | 32 | Handler address |
| irq_pending | output | 1 | Enabled, unmasked interrupt present |
| user_mode | output | 1 | Current kernel/user bit, 1 = user |

## Verification
The hardest cases to reach are the collisions: an exception in the same cycle as a return, a return together with a Status write, and an exception together with an EPC write. In normal flow these events come from different pipeline stages and rarely coincide. Dedicated tasks raise them together on one clock edge and then read Status or EPC back to see that only the higher-priority event took effect. Stack contents are chosen so that every bit pair is distinct, which makes a wrong shift direction or a corrupted old pair show up in a single read.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int XLEN       = 32;
  localparam int SEL_W      = 5;
  localparam int CODE_W     = 5;
  localparam int COP_W      = 2;
  localparam int HW_IRQ_W   = 6;
  localparam int SW_IRQ_W   = 2;
  localparam int IRQ_W      = HW_IRQ_W + SW_IRQ_W;
  localparam int STACK_W    = 6;

  localparam logic [SEL_W-1:0] SEL_STATUS = 5'd12;
  localparam logic [SEL_W-1:0] SEL_CAUSE  = 5'd13;
  localparam logic [SEL_W-1:0] SEL_EPC    = 5'd14;

  localparam logic [XLEN-1:0] STATUS_KEEP = 32'hF27F_FF3F;
  localparam logic [XLEN-1:0] CAUSE_KEEP  = 32'hB000_FF7C;

  localparam int BIT_BEV   = 22;
  localparam int BIT_IEC   = 0;
  localparam int BIT_KUC   = 1;
  localparam int IRQ_LSB   = 8;
  localparam int IRQ_MSB   = IRQ_LSB + IRQ_W - 1;
  localparam int SLOT_STEP = 4;
endpackage

// File: rtl/trap_status.sv
module trap_status
  import trap_pkg::*;
#(
  parameter logic RESET_BEV = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic            wr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] status_q
);
  localparam logic [XLEN-1:0] RESET_VAL = XLEN'(RESET_BEV) << BIT_BEV;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= RESET_VAL;
    end else if (push) begin
      status_q[STACK_W-1:0] <= {status_q[STACK_W-3:0], 2'b00};
    end else if (pop) begin
      status_q[STACK_W-3:0] <= status_q[STACK_W-1:2];
    end else if (wr) begin
      status_q <= wdata & STATUS_KEEP;
    end
  end
endmodule

// File: rtl/trap_cause.sv
module trap_cause
  import trap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [CODE_W-1:0]   code,
  input  logic [COP_W-1:0]    cop,
  input  logic                in_delay,
  input  logic [XLEN-1:0]     pc,
  input  logic [HW_IRQ_W-1:0] hw_irq,
  input  logic                sw_wr,
  input  logic                epc_wr,
  input  logic [XLEN-1:0]     wdata,
  output logic [XLEN-1:0]     cause_q,
  output logic [XLEN-1:0]     epc_q
);
  logic                bd_q;
  logic [COP_W-1:0]    ce_q;
  logic [CODE_W-1:0]   code_q;
  logic [SW_IRQ_W-1:0] sw_q;
  logic [HW_IRQ_W-1:0] hw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hw_q <= '0;
    else        hw_q <= hw_irq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bd_q   <= 1'b0;
      ce_q   <= '0;
      code_q <= '0;
      sw_q   <= '0;
      epc_q  <= '0;
    end else if (push) begin
      bd_q   <= in_delay;
      ce_q   <= cop;
      code_q <= code;
      epc_q  <= in_delay ? pc - XLEN'(SLOT_STEP) : pc;
    end else begin
      if (sw_wr)  sw_q  <= wdata[IRQ_LSB +: SW_IRQ_W];
      if (epc_wr) epc_q <= wdata;
    end
  end

  always_comb begin
    cause_q = '0;
    cause_q[31]                            = bd_q;
    cause_q[29:28]                         = ce_q;
    cause_q[IRQ_LSB + SW_IRQ_W +: HW_IRQ_W] = hw_q;
    cause_q[IRQ_LSB +: SW_IRQ_W]           = sw_q;
    cause_q[2 +: CODE_W]                   = code_q;
  end
endmodule

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter logic [XLEN-1:0] BOOT_BASE  = 32'hBFC0_0100,
  parameter logic [XLEN-1:0] NORM_BASE  = 32'h8000_0000,
  parameter logic [XLEN-1:0] GEN_OFFSET = 32'h0000_0080
) (
  input  logic [XLEN-1:0] status_q,
  input  logic [XLEN-1:0] cause_q,
  input  logic            user_refill,
  output logic [XLEN-1:0] vector_addr,
  output logic            irq_pending
);
  logic [IRQ_W-1:0] live;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_live
    assign live[i] = cause_q[IRQ_LSB + i] & status_q[IRQ_LSB + i];
  end

  assign irq_pending = status_q[BIT_IEC] & (|live);
  assign vector_addr = (status_q[BIT_BEV] ? BOOT_BASE : NORM_BASE)
                     + (user_refill ? '0 : GEN_OFFSET);
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter logic            RESET_BEV  = 1'b1,
  parameter logic [XLEN-1:0] BOOT_BASE  = 32'hBFC0_0100,
  parameter logic [XLEN-1:0] NORM_BASE  = 32'h8000_0000,
  parameter logic [XLEN-1:0] GEN_OFFSET = 32'h0000_0080
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exc_req,
  input  logic [CODE_W-1:0]   exc_code,
  input  logic [XLEN-1:0]     exc_pc,
  input  logic                exc_in_delay,
  input  logic [COP_W-1:0]    exc_cop,
  input  logic                exc_user_refill,
  input  logic [HW_IRQ_W-1:0] hw_irq,
  input  logic                ret_req,
  input  logic                reg_wr,
  input  logic [SEL_W-1:0]    reg_sel,
  input  logic [XLEN-1:0]     reg_wdata,
  output logic [XLEN-1:0]     reg_rdata,
  output logic [XLEN-1:0]     vector_addr,
  output logic                irq_pending,
  output logic                user_mode
);
  logic [XLEN-1:0] status_q;
  logic [XLEN-1:0] cause_q;
  logic [XLEN-1:0] epc_q;
  logic            do_pop;
  logic            do_wr;

  // exception beats return beats register write
  assign do_pop = ret_req & ~exc_req;
  assign do_wr  = reg_wr & ~exc_req & ~ret_req;

  trap_status #(.RESET_BEV(RESET_BEV)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (exc_req),
    .pop      (do_pop),
    .wr       (do_wr && reg_sel == SEL_STATUS),
    .wdata    (reg_wdata),
    .status_q (status_q)
  );

  trap_cause u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (exc_req),
    .code     (exc_code),
    .cop      (exc_cop),
    .in_delay (exc_in_delay),
    .pc       (exc_pc),
    .hw_irq   (hw_irq),
    .sw_wr    (do_wr && reg_sel == SEL_CAUSE),
    .epc_wr   (do_wr && reg_sel == SEL_EPC),
    .wdata    (reg_wdata),
    .cause_q  (cause_q),
    .epc_q    (epc_q)
  );

  trap_route #(
    .BOOT_BASE  (BOOT_BASE),
    .NORM_BASE  (NORM_BASE),
    .GEN_OFFSET (GEN_OFFSET)
  ) u_route (
    .status_q    (status_q),
    .cause_q     (cause_q),
    .user_refill (exc_user_refill),
    .vector_addr (vector_addr),
    .irq_pending (irq_pending)
  );

  always_comb begin
    unique case (reg_sel)
      SEL_STATUS: reg_rdata = status_q;
      SEL_CAUSE:  reg_rdata = cause_q;
      SEL_EPC:    reg_rdata = epc_q;
      default:    reg_rdata = '0;
    endcase
  end

  assign user_mode = status_q[BIT_KUC];
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk
  import trap_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            exc_req,
  input logic            ret_req,
  input logic [XLEN-1:0] exc_pc,
  input logic            exc_in_delay,
  input logic            irq_pending,
  input logic [XLEN-1:0] status_q,
  input logic [XLEN-1:0] cause_q,
  input logic [XLEN-1:0] epc_q
);
  // R2
  status_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~STATUS_KEEP) == '0);

  // R2 R3
  cause_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q & ~CAUSE_KEEP) == '0);

  // R6
  stack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> status_q[5:0] == {$past(status_q[3:0]), 2'b00});

  // R7 R11
  stack_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !exc_req) |=>
      (status_q[3:0] == $past(status_q[5:2]) && status_q[5:4] == $past(status_q[5:4])));

  // R5
  slot_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && exc_in_delay) |=> (epc_q == $past(exc_pc) - 32'd4 && cause_q[31]));

  // R4
  plain_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !exc_in_delay) |=> (epc_q == $past(exc_pc) && !cause_q[31]));

  // R9
  pending_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> status_q[BIT_IEC]);
endmodule

bind trap_ctrl trap_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .exc_req      (exc_req),
  .ret_req      (ret_req),
  .exc_pc       (exc_pc),
  .exc_in_delay (exc_in_delay),
  .irq_pending  (irq_pending),
  .status_q     (status_q),
  .cause_q      (cause_q),
  .epc_q        (epc_q)
);

// File: tb/trap_ctrl_test.sv
module trap_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [31:0] exc_pc = '0;
  logic        exc_in_delay = 1'b0;
  logic [1:0]  exc_cop = '0;
  logic        exc_user_refill = 1'b0;
  logic [5:0]  hw_irq = '0;
  logic        ret_req = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] vector_addr;
  logic        irq_pending;
  logic        user_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trap_ctrl uut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
    .exc_pc(exc_pc), .exc_in_delay(exc_in_delay), .exc_cop(exc_cop),
    .exc_user_refill(exc_user_refill), .hw_irq(hw_irq), .ret_req(ret_req),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .vector_addr(vector_addr),
    .irq_pending(irq_pending), .user_mode(user_mode)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] sel, output logic [31:0] val);
    reg_sel = sel;
    #1;
    val = reg_rdata;
  endtask

  task automatic wr(input logic [4:0] sel, input logic [31:0] data);
    reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic set_exc(input logic [4:0] code, input logic [31:0] pc,
                         input logic dly, input logic [1:0] cop);
    exc_code = code; exc_pc = pc; exc_in_delay = dly; exc_cop = cop; exc_req = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'd12, v); check("R1 status reset", v, 32'h0040_0000);
    rd(5'd13, v); check("R1 cause reset", v, 32'h0);
    rd(5'd14, v); check("R1 epc reset", v, 32'h0);
    check("R1 user_mode reset", {31'b0, user_mode}, 32'h0);
    check("R10 boot vector", vector_addr, 32'hBFC0_0180);
    exc_user_refill = 1'b1; #1;
    check("R10 boot refill vector", vector_addr, 32'hBFC0_0100);
    exc_user_refill = 1'b0;
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(5'd12, 32'hFFFF_FFFF);
    rd(5'd12, v); check("R2 status mask", v, 32'hF27F_FF3F);
    wr(5'd5, 32'hFFFF_FFFF);
    rd(5'd5, v); check("R2 unmapped reads zero", v, 32'h0);
    rd(5'd12, v); check("R2 unmapped write no effect", v, 32'hF27F_FF3F);
    wr(5'd13, 32'hFFFF_FFFF);
    rd(5'd13, v); check("R3 cause only sw bits", v, 32'h0000_0300);
    wr(5'd14, 32'hDEAD_BEEF);
    rd(5'd14, v); check("R3 epc full write", v, 32'hDEAD_BEEF);
    wr(5'd12, 32'h0);
    check("R10 normal vector", vector_addr, 32'h8000_0080);
    exc_user_refill = 1'b1; #1;
    check("R10 normal refill vector", vector_addr, 32'h8000_0000);
    exc_user_refill = 1'b0;
  endtask

  task automatic t_exc_ret();
    logic [31:0] v;
    wr(5'd12, 32'h0000_0027);
    check("R12 user_mode set", {31'b0, user_mode}, 32'h1);
    set_exc(5'd11, 32'h0040_1000, 1'b0, 2'd2);
    step(); exc_req = 1'b0;
    rd(5'd13, v); check("R4 cause code and cop", v, 32'h2000_032C);
    rd(5'd14, v); check("R4 epc plain", v, 32'h0040_1000);
    rd(5'd12, v); check("R6 stack push", v, 32'h0000_001C);
    check("R12 kernel after entry", {31'b0, user_mode}, 32'h0);
    ret_req = 1'b1; step(); ret_req = 1'b0;
    rd(5'd12, v); check("R7 stack pop", v, 32'h0000_0017);
    check("R12 user after return", {31'b0, user_mode}, 32'h1);
    set_exc(5'd4, 32'h8000_1004, 1'b1, 2'd0);
    step(); exc_req = 1'b0;
    rd(5'd14, v); check("R5 epc delay slot", v, 32'h8000_1000);
    rd(5'd13, v); check("R5 cause bd set", v, 32'h8000_0310);
    rd(5'd12, v); check("R6 second push", v, 32'h0000_001C);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(5'd13, 32'h0000_0300);
    wr(5'd12, 32'h0000_0401);
    check("R9 no pending masked", {31'b0, irq_pending}, 32'h0);
    hw_irq = 6'b000001; #1;
    check("R8 line lag one cycle", {31'b0, irq_pending}, 32'h0);
    step();
    rd(5'd13, v); check("R8 hw line in cause", v & 32'h0000_FF00, 32'h0000_0700);
    check("R9 hw pending", {31'b0, irq_pending}, 32'h1);
    wr(5'd12, 32'h0000_0400);
    check("R9 gated by enable", {31'b0, irq_pending}, 32'h0);
    wr(5'd12, 32'h0000_0101);
    check("R9 sw pending", {31'b0, irq_pending}, 32'h1);
    wr(5'd13, 32'h0);
    check("R9 sw cleared", {31'b0, irq_pending}, 32'h0);
    wr(5'd13, 32'h0000_0100);
    check("R9 sw set again", {31'b0, irq_pending}, 32'h1);
    set_exc(5'd0, 32'h0000_2000, 1'b0, 2'd0);
    step(); exc_req = 1'b0;
    check("R6 R9 entry masks pending", {31'b0, irq_pending}, 32'h0);
    hw_irq = 6'b0;
  endtask

  task automatic t_prio();
    logic [31:0] v;
    wr(5'd12, 32'h0000_0009);
    set_exc(5'd8, 32'h0000_3000, 1'b0, 2'd0);
    ret_req = 1'b1;
    step(); exc_req = 1'b0; ret_req = 1'b0;
    rd(5'd12, v); check("R11 exception beats return", v, 32'h0000_0024);
    ret_req = 1'b1;
    wr(5'd12, 32'hFFFF_FFFF);
    ret_req = 1'b0;
    rd(5'd12, v); check("R11 return beats write", v, 32'h0000_0029);
    set_exc(5'd9, 32'h0000_0100, 1'b0, 2'd0);
    wr(5'd14, 32'h1234_5678);
    exc_req = 1'b0;
    rd(5'd14, v); check("R11 exception beats write", v, 32'h0000_0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_exc_ret();
    t_irq();
    t_prio();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule